// File: doc/BRIEF.md
# Segmented Thermometer-to-Binary Encoder

This block is the digital back end of an 8-bit flash converter. A bank of 256 comparators delivers a thermometer vector. The block registers that vector on the rising clock edge. It then cuts the vector into four 64-bit columns and reduces each column, in parallel, to a 6-bit position and an occupancy flag. These column results are latched on the falling edge.

On the next rising edge the topmost occupied column is chosen. Its slot gives the two upper code bits and its position gives the six lower bits. Optional inversion of the upper bit and of the lower seven bits is applied, and the word is registered to the outputs.

When every comparator has tripped, the block raises an overrange flag and drives all eight code bits high, whatever the inversion settings are. A ready output follows the pipeline fill after reset, so a downstream register can use it to qualify the code word. Its polarity can be selected.

Top module: `therm_seg_encoder`

## Requirements
- R1: For a clean thermometer whose highest set bit is at index h (bit 0 is the lowest threshold), with both inversions off, `code_o` equals h. When no bit is set, `code_o` is 0.
- R2: A vector present at rising edge N appears on `code_o` and `ovr_o` after rising edge N+1. This is one clock of latency, and a new vector is accepted every cycle.
- R3: Bits 64c+63 down to 64c form column c. `code_o[7:6]` equals c for the highest column holding a set bit, and `code_o[5:0]` is the position of the highest set bit inside that column.
- R4: Bubbles are not corrected. An isolated set bit above the thermometer edge sets the code to that bit's index.
- R5: With `msb_inv_i`=1, only `code_o[7]` is inverted relative to R1.
- R6: With `lsb_inv_i`=1, `code_o[6:0]` are inverted and `code_o[7]` is unchanged.
- R7: When all 256 input bits are set, `ovr_o`=1 and `code_o`=8'hFF under every inversion setting. In every other case `ovr_o`=0.
- R8: `rdy_o` holds its inactive level until the first converted word reaches the outputs after reset, and is active from then on. The active level is 1 when `rdy_inv_i`=0 and 0 when `rdy_inv_i`=1. The inversion controls are sampled on the same rising edge that loads the output word.
- R9: While `rst_n` is low, `code_o`=0, `ovr_o`=0 and `rdy_o`=0. Reset takes effect asynchronously and is released on the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; rising edge captures, falling edge latches columns |
| rst_n | input | 1 | Asynchronous active-low reset |
| therm_i | input | 256 | Comparator thermometer vector, bit 0 lowest threshold |
| msb_inv_i | input | 1 | Invert code bit 7 |
| lsb_inv_i | input | 1 | Invert code bits 6 to 0 |
| rdy_inv_i | input | 1 | Select active-low ready polarity |
| code_o | output | 8 | Registered output code |
| ovr_o | output | 1 | Overrange flag |
| rdy_o | output | 1 | Data-ready level with selectable polarity |

## Verification
The column checks assume that the captured vector holds known values at every rising edge, and that the clock keeps running through the two-flop reset release, so the falling-edge latches always hold the encode of the vector that is still in the capture register. The bench drives all 256 inputs from computed patterns a nanosecond after each rising edge. This keeps input changes clear of both clock edges and holds the controls steady across each conversion. Bubble patterns are placed on purpose to exercise the uncorrected highest-bit rule without breaking these assumptions.

// File: rtl/tenc_pkg.sv
package tenc_pkg;
  localparam int NUM_COLS_D = 4;
  localparam int COL_W_D    = 64;
endpackage

// File: rtl/tenc_rst_sync.sv
module tenc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic s1_q;
  logic s1_d;
  logic s2_d;

  always_comb begin
    s1_d = 1'b1;
    s2_d = s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      s1_q    <= s1_d;
      rst_n_s <= s2_d;
    end
  end
endmodule

// File: rtl/tenc_col.sv
module tenc_col #(
  parameter int COL_W = tenc_pkg::COL_W_D
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [COL_W-1:0]         bits_i,
  output logic                     occ_o,
  output logic [$clog2(COL_W)-1:0] fine_o
);
  localparam int FINE_W = $clog2(COL_W);

  logic              occ_d;
  logic [FINE_W-1:0] fine_d;

  // highest set bit wins; no bubble correction
  always_comb begin
    fine_d = '0;
    for (int i = 0; i < COL_W; i++) begin
      if (bits_i[i]) fine_d = FINE_W'(i);
    end
    occ_d = |bits_i;
  end

  // column latch tracks on the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_o  <= 1'b0;
      fine_o <= '0;
    end else begin
      occ_o  <= occ_d;
      fine_o <= fine_d;
    end
  end

  // at the rising edge the capture register still holds the latched source
  AST_COL_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    occ_o |-> bits_i[fine_o]); // R3
  AST_COL_NOTHING_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    occ_o |-> ((bits_i >> fine_o) == COL_W'(1))); // R4
  AST_COL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !occ_o |-> (bits_i == '0)); // R3
endmodule

// File: rtl/tenc_merge.sv
module tenc_merge #(
  parameter int NUM_COLS = tenc_pkg::NUM_COLS_D,
  parameter int FINE_W   = $clog2(tenc_pkg::COL_W_D)
) (
  input  logic [NUM_COLS-1:0]                    occ_i,
  input  logic [NUM_COLS*FINE_W-1:0]             fine_i,
  output logic [$clog2(NUM_COLS)+FINE_W-1:0]     code_o
);
  localparam int IDX_W = $clog2(NUM_COLS);

  logic [IDX_W-1:0] sel;
  logic             hit;

  // slot 0 is the top column; lowest occupied slot is chosen
  always_comb begin
    sel = '0;
    hit = 1'b0;
    for (int k = NUM_COLS - 1; k >= 0; k--) begin
      if (occ_i[k]) begin
        sel = IDX_W'(k);
        hit = 1'b1;
      end
    end
    if (hit) code_o = {IDX_W'(NUM_COLS - 1) - sel, fine_i[sel*FINE_W +: FINE_W]};
    else     code_o = '0;
  end
endmodule

// File: rtl/therm_seg_encoder.sv
module therm_seg_encoder #(
  parameter int NUM_COLS = tenc_pkg::NUM_COLS_D,
  parameter int COL_W    = tenc_pkg::COL_W_D
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic [NUM_COLS*COL_W-1:0]                therm_i,
  input  logic                                     msb_inv_i,
  input  logic                                     lsb_inv_i,
  input  logic                                     rdy_inv_i,
  output logic [$clog2(NUM_COLS)+$clog2(COL_W)-1:0] code_o,
  output logic                                     ovr_o,
  output logic                                     rdy_o
);
  localparam int THERM_W = NUM_COLS * COL_W;
  localparam int FINE_W  = $clog2(COL_W);
  localparam int IDX_W   = $clog2(NUM_COLS);
  localparam int CODE_W  = IDX_W + FINE_W;

  logic                       rst_n_s;
  logic [THERM_W-1:0]         cap_q;
  logic                       vcap_q;
  logic [NUM_COLS-1:0]        occ_q;
  logic [NUM_COLS*FINE_W-1:0] fine_q;
  logic                       ovr_q;
  logic                       vcol_q;
  logic [CODE_W-1:0]          merged;
  logic [CODE_W-1:0]          inv_mask;
  logic [CODE_W-1:0]          code_d;
  logic                       ovr_d;
  logic                       rdy_d;
  logic                       ovr_lat_d;

  tenc_rst_sync i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  // stage 1: capture on the rising edge
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cap_q  <= '0;
      vcap_q <= 1'b0;
    end else begin
      cap_q  <= therm_i;
      vcap_q <= 1'b1;
    end
  end

  // stage 2: per-column encode, latched on the falling edge
  for (genvar k = 0; k < NUM_COLS; k++) begin : g_col
    tenc_col #(.COL_W(COL_W)) i_col (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .bits_i (cap_q[(NUM_COLS-1-k)*COL_W +: COL_W]),
      .occ_o  (occ_q[k]),
      .fine_o (fine_q[k*FINE_W +: FINE_W])
    );
  end

  always_comb ovr_lat_d = &cap_q;

  always_ff @(negedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ovr_q  <= 1'b0;
      vcol_q <= 1'b0;
    end else begin
      ovr_q  <= ovr_lat_d;
      vcol_q <= vcap_q;
    end
  end

  // stage 3: merge, invert, saturate, register
  tenc_merge #(.NUM_COLS(NUM_COLS), .FINE_W(FINE_W)) i_merge (
    .occ_i  (occ_q),
    .fine_i (fine_q),
    .code_o (merged)
  );

  always_comb begin
    inv_mask = {msb_inv_i, {(CODE_W-1){lsb_inv_i}}};
    code_d   = ovr_q ? {CODE_W{1'b1}} : (merged ^ inv_mask);
    ovr_d    = ovr_q;
    rdy_d    = vcol_q ^ rdy_inv_i;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      code_o <= '0;
      ovr_o  <= 1'b0;
      rdy_o  <= 1'b0;
    end else begin
      code_o <= code_d;
      ovr_o  <= ovr_d;
      rdy_o  <= rdy_d;
    end
  end

  AST_OVR_SATURATES: assert property (@(posedge clk) disable iff (!rst_n_s)
    ovr_o |-> (code_o == {CODE_W{1'b1}})); // R7
  AST_TOP_COLUMN_MSBS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (occ_q[0] && !ovr_q && !msb_inv_i && !lsb_inv_i)
    |=> (code_o == {{IDX_W{1'b1}}, $past(fine_q[FINE_W-1:0])})); // R3
  AST_MSB_INV_ONLY_TOP: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ovr_q && msb_inv_i && !lsb_inv_i && !occ_q[0] && !occ_q[1])
    |=> code_o[CODE_W-1]); // R5
endmodule

// File: tb/test_therm_seg_encoder.sv
`timescale 1ns/1ps
module test_therm_seg_encoder;
  logic         clk;
  logic         rst_n;
  logic [255:0] therm;
  logic         minv;
  logic         linv;
  logic         rinv;
  logic [7:0]   code;
  logic         ovr;
  logic         rdy;
  int           total = 0;
  int           bad = 0;
  logic         done = 1'b0;

  therm_seg_encoder i_therm_seg_encoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .therm_i   (therm),
    .msb_inv_i (minv),
    .lsb_inv_i (linv),
    .rdy_inv_i (rinv),
    .code_o    (code),
    .ovr_o     (ovr),
    .rdy_o     (rdy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // fields: [31:23] ones from bit 0, [22:14] extra set bit (511 none),
  // [13] msb_inv, [12] lsb_inv, [11] expected ovr, [7:0] expected code
  localparam int NV = 19;
  localparam logic [31:0] VEC [NV] = '{
    {9'd0,   9'd511, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00}, // R1 empty
    {9'd1,   9'd511, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00}, // R1
    {9'd2,   9'd511, 1'b0, 1'b0, 1'b0, 3'd0, 8'h01}, // R1
    {9'd64,  9'd511, 1'b0, 1'b0, 1'b0, 3'd0, 8'h3F}, // R3 top of column 0
    {9'd65,  9'd511, 1'b0, 1'b0, 1'b0, 3'd0, 8'h40}, // R3 column 1
    {9'd128, 9'd511, 1'b0, 1'b0, 1'b0, 3'd0, 8'h7F}, // R3
    {9'd129, 9'd511, 1'b0, 1'b0, 1'b0, 3'd0, 8'h80}, // R3 column 2
    {9'd200, 9'd511, 1'b0, 1'b0, 1'b0, 3'd0, 8'hC7}, // R1
    {9'd255, 9'd511, 1'b0, 1'b0, 1'b0, 3'd0, 8'hFE}, // R7 one short
    {9'd256, 9'd511, 1'b0, 1'b0, 1'b1, 3'd0, 8'hFF}, // R7
    {9'd10,  9'd100, 1'b0, 1'b0, 1'b0, 3'd0, 8'h64}, // R4 bubble
    {9'd0,   9'd255, 1'b0, 1'b0, 1'b0, 3'd0, 8'hFF}, // R4 lone top bit, no ovr
    {9'd200, 9'd511, 1'b1, 1'b0, 1'b0, 3'd0, 8'h47}, // R5
    {9'd200, 9'd511, 1'b0, 1'b1, 1'b0, 3'd0, 8'hB8}, // R6
    {9'd65,  9'd511, 1'b1, 1'b1, 1'b0, 3'd0, 8'hBF}, // R5 R6
    {9'd256, 9'd511, 1'b1, 1'b1, 1'b1, 3'd0, 8'hFF}, // R7
    {9'd256, 9'd511, 1'b1, 1'b0, 1'b1, 3'd0, 8'hFF}, // R7
    {9'd0,   9'd511, 1'b0, 1'b1, 1'b0, 3'd0, 8'h7F}, // R6
    {9'd70,  9'd3,   1'b0, 1'b0, 1'b0, 3'd0, 8'h45}  // R4 bubble below edge
  };

  function automatic logic [255:0] mk(int lvl, int ex);
    logic [255:0] t = '0;
    for (int i = 0; i < lvl; i++) t[i] = 1'b1;
    if (ex < 256) t[ex] = 1'b1;
    return t;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1;
    therm = '0;
    minv = 1'b0;
    linv = 1'b0;
    rinv = 1'b0;
    #1 rst_n = 1'b0;
    therm = mk(200, 511);
    #1;
    chk("R9 code in reset", code, 8'h00);
    chk("R9 ovr in reset", {7'd0, ovr}, 8'h00);
    chk("R9 rdy in reset", {7'd0, rdy}, 8'h00);
    repeat (3) tick();
    chk("R9 code held", code, 8'h00);
    rst_n = 1'b1;
    tick();
    chk("R8 not ready right after release", {7'd0, rdy}, 8'h00);
    repeat (6) tick();
    chk("R8 ready after fill", {7'd0, rdy}, 8'h01);
    rinv = 1'b1;
    tick();
    chk("R8 inverted polarity", {7'd0, rdy}, 8'h00);
    rinv = 1'b0;
    tick();
    chk("R8 polarity restored", {7'd0, rdy}, 8'h01);

    // table walk: drive after edge A, result after edge B
    for (int v = 0; v < NV; v++) begin
      therm = mk(int'(VEC[v][31:23]), int'(VEC[v][22:14]));
      minv  = VEC[v][13];
      linv  = VEC[v][12];
      tick();
      tick();
      chk($sformatf("R1/R3-R7 vec %0d code", v), code, VEC[v][7:0]);
      chk($sformatf("R7 vec %0d ovr", v), {7'd0, ovr}, {7'd0, VEC[v][11]});
    end

    // back-to-back latency
    minv = 1'b0;
    linv = 1'b0;
    therm = mk(5, 511);
    tick();
    therm = mk(70, 511);
    tick();
    chk("R2 first word", code, 8'h04);
    therm = mk(256, 511);
    tick();
    chk("R2 second word", code, 8'h45);
    therm = mk(0, 511);
    tick();
    chk("R2 ovr word", {7'd0, ovr}, 8'h01);
    tick();
    chk("R2 ovr clears", {7'd0, ovr}, 8'h00);
    chk("R1 empty after ovr", code, 8'h00);

    // reset mid-run
    therm = mk(150, 511);
    tick();
    tick();
    rst_n = 1'b0;
    #1;
    chk("R9 async clear", code, 8'h00);
    chk("R9 rdy clear", {7'd0, rdy}, 8'h00);
    tick();
    rst_n = 1'b1;
    repeat (8) tick();
    chk("R1 after re-reset", code, 8'h95);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule